// File: doc/BRIEF.md
# Tiled Buffer Address Generator

This block walks a two-dimensional buffer tile by tile and emits one linear element address per handshake. Software-side logic presents the buffer extent, the tile extent, a start offset and a two-entry traversal list on input pins, then pulses `start`. The block takes a copy of these settings and runs on its own until the last address has been accepted. It works the same way for a writer that fills a buffer and for a reader that drains one.

Inside a tile, the column index (dimension 0) changes fastest. Tiles are visited in the order set by the traversal list. Each entry names a dimension, a stride and a wrap count. The first entry is the inner tile loop and the second is the outer tile loop. A stride smaller than the tile extent gives overlapping tiles, and the shared elements are emitted again for each tile that contains them. Each address carries two flags: one marks the final element of a tile and the other marks the final element of the transfer.

Any element that falls outside the buffer is skipped, and a sticky error flag is raised.

Top module: `tag_addr_gen`

## Requirements
- R1: After reset, `busy`, `out_valid` and `err` are low.
- R2: When `start` is high while the block is idle, the configuration is copied and `busy` is high from the next cycle. The copy is refused (`busy` stays low) if a tile extent or a wrap count is zero. Once running, further `start` pulses and changes on the configuration inputs have no effect on the emitted sequence.
- R3: Within a tile, the element offset (i0, i1) steps i0 from 0 to tile0-1 first, then advances i1, until i1 reaches tile1-1.
- R4: Traversal entry A (`a_*`) is the inner tile loop and entry B (`b_*`) is the outer one. A dim field of 0 selects dimension 0 (columns) and 1 selects dimension 1 (rows). A level's tile origin takes `wrap` positions spaced by `stride`, starting from 0. When that level wraps, it returns to 0 and the outer level advances. When both entries name the same dimension, their origins add.
- R5: Each emitted address equals (off1 + org1 + i1) * buf0 + (off0 + org0 + i0), in element units.
- R6: The transfer visits tile0 * tile1 * a_wrap * b_wrap element positions. Positions shared by overlapping tiles are emitted once for each tile.
- R7: `out_tile_last` is high on the element with i0 = tile0-1 and i1 = tile1-1. `out_xfer_last` is high only on the final element of the final tile. After that element is accepted, `busy` is low on the next cycle.
- R8: An address is accepted when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the address and both flags hold, and `out_valid` stays high.
- R9: An element whose column coordinate is at or above buf0, or whose row coordinate is at or above buf1, is not emitted. It raises `err`, which stays high until reset or the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a transfer (taken only when idle) |
| buf0 | input | 8 | Buffer extent along dimension 0 |
| buf1 | input | 8 | Buffer extent along dimension 1 |
| tile0 | input | 8 | Tile extent along dimension 0 |
| tile1 | input | 8 | Tile extent along dimension 1 |
| off0 | input | 8 | Start offset along dimension 0 |
| off1 | input | 8 | Start offset along dimension 1 |
| a_dim | input | 1 | Inner traversal level dimension |
| a_stride | input | 8 | Inner traversal level stride |
| a_wrap | input | 8 | Inner traversal level position count |
| b_dim | input | 1 | Outer traversal level dimension |
| b_stride | input | 8 | Outer traversal level stride |
| b_wrap | input | 8 | Outer traversal level position count |
| busy | output | 1 | Transfer in progress |
| out_valid | output | 1 | Address available |
| out_ready | input | 1 | Consumer accepts the address |
| out_addr | output | 16 | Linear element address |
| out_tile_last | output | 1 | Last element of the current tile |
| out_xfer_last | output | 1 | Last element of the transfer |
| err | output | 1 | Sticky out-of-bounds flag |

## Verification
The first address is due in the cycle right after the edge that accepts `start`. It comes straight from the counter registers with no extra pipeline stage. Each accepted handshake advances the address by exactly one register update, and a skipped out-of-bounds element takes one cycle with `out_valid` low. The bench drives `start` and `out_ready` on the falling edge, samples the outputs one time unit later, and pops the expected queue only when it sees `out_valid` and `out_ready` high together. A stalled cycle is compared against the value seen on the previous falling edge. `busy` is checked one edge after start and again one edge after the final handshake.

// File: rtl/tag_pkg.sv
package tag_pkg;
    localparam int CW = 8;                    // configuration field width
    localparam int WW = 8;                    // wrap count width
    localparam int LW = (CW > WW) ? CW : WW;  // level counter width
    localparam int XW = CW + WW + 2;          // coordinate width
    localparam int AW = 2 * CW;               // address width
    localparam int NLVL = 4;                  // i0, i1, traversal A, traversal B

    typedef struct packed {
        logic          dim;
        logic [CW-1:0] stride;
        logic [WW-1:0] wrap;
    } lvl_t;

    typedef struct packed {
        logic [CW-1:0] bsz0;
        logic [CW-1:0] bsz1;
        logic [CW-1:0] tsz0;
        logic [CW-1:0] tsz1;
        logic [CW-1:0] off0;
        logic [CW-1:0] off1;
        lvl_t          la;
        lvl_t          lb;
    } cfg_t;

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} st_t;

    function automatic logic cfg_ok(cfg_t c);
        return (c.tsz0 != '0) && (c.tsz1 != '0) &&
               (c.la.wrap != '0) && (c.lb.wrap != '0);
    endfunction
endpackage

// File: rtl/tag_level.sv
module tag_level #(
    parameter int LW = 8,
    parameter int XW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    input  logic [LW-1:0] stride,
    input  logic [LW-1:0] wrap,
    output logic          last,
    output logic [XW-1:0] pos
);
    logic [LW-1:0] cnt;

    assign last = (cnt == wrap - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            pos <= '0;
        end else if (step) begin
            if (last) begin
                cnt <= '0;
                pos <= '0;
            end else begin
                cnt <= cnt + 1'b1;
                pos <= pos + XW'(stride);
            end
        end
    end
endmodule

// File: rtl/tag_addr_calc.sv
module tag_addr_calc
    import tag_pkg::*;
(
    input  cfg_t          cfg,
    input  logic [XW-1:0] p_i0,
    input  logic [XW-1:0] p_i1,
    input  logic [XW-1:0] p_a,
    input  logic [XW-1:0] p_b,
    output logic          inb,
    output logic [AW-1:0] addr
);
    logic [XW-1:0]    c0, c1;
    logic [XW+CW-1:0] prod;

    always_comb begin
        c0 = XW'(cfg.off0) + p_i0;
        c1 = XW'(cfg.off1) + p_i1;
        if (cfg.la.dim) c1 = c1 + p_a; else c0 = c0 + p_a;
        if (cfg.lb.dim) c1 = c1 + p_b; else c0 = c0 + p_b;
        inb  = (c0 < XW'(cfg.bsz0)) && (c1 < XW'(cfg.bsz1));
        prod = (XW+CW)'(c1) * (XW+CW)'(cfg.bsz0) + (XW+CW)'(c0);
        addr = prod[AW-1:0];
    end
endmodule

// File: rtl/tag_addr_gen.sv
module tag_addr_gen
    import tag_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] buf0,
    input  logic [CW-1:0] buf1,
    input  logic [CW-1:0] tile0,
    input  logic [CW-1:0] tile1,
    input  logic [CW-1:0] off0,
    input  logic [CW-1:0] off1,
    input  logic          a_dim,
    input  logic [CW-1:0] a_stride,
    input  logic [WW-1:0] a_wrap,
    input  logic          b_dim,
    input  logic [CW-1:0] b_stride,
    input  logic [WW-1:0] b_wrap,
    output logic          busy,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [AW-1:0] out_addr,
    output logic          out_tile_last,
    output logic          out_xfer_last,
    output logic          err
);
    cfg_t          cfg_in, cfg_q;
    st_t           st;
    logic          accept, inb, adv;
    logic [NLVL-1:0] lvl_step, lvl_last;
    logic [LW-1:0]   lvl_stride [NLVL];
    logic [LW-1:0]   lvl_wrap   [NLVL];
    logic [XW-1:0]   lvl_pos    [NLVL];

    always_comb begin
        cfg_in = '{bsz0: buf0, bsz1: buf1, tsz0: tile0, tsz1: tile1,
                   off0: off0, off1: off1,
                   la: '{dim: a_dim, stride: a_stride, wrap: a_wrap},
                   lb: '{dim: b_dim, stride: b_stride, wrap: b_wrap}};
    end

    assign accept = start && (st == ST_IDLE) && cfg_ok(cfg_in);
    assign adv    = (st == ST_RUN) && (inb ? out_ready : 1'b1);

    always_comb begin
        lvl_stride[0] = LW'(1);            lvl_wrap[0] = LW'(cfg_q.tsz0);
        lvl_stride[1] = LW'(1);            lvl_wrap[1] = LW'(cfg_q.tsz1);
        lvl_stride[2] = LW'(cfg_q.la.stride); lvl_wrap[2] = LW'(cfg_q.la.wrap);
        lvl_stride[3] = LW'(cfg_q.lb.stride); lvl_wrap[3] = LW'(cfg_q.lb.wrap);
    end

    genvar k;
    generate
        for (k = 0; k < NLVL; k++) begin : g_lvl
            if (k == 0) begin : g_first
                assign lvl_step[k] = adv;
            end else begin : g_chain
                assign lvl_step[k] = lvl_step[k-1] && lvl_last[k-1];
            end
            tag_level #(.LW(LW), .XW(XW)) u_lvl (
                .clk    (clk),
                .rst    (rst),
                .clr    (accept),
                .step   (lvl_step[k]),
                .stride (lvl_stride[k]),
                .wrap   (lvl_wrap[k]),
                .last   (lvl_last[k]),
                .pos    (lvl_pos[k])
            );
        end
    endgenerate

    tag_addr_calc u_calc (
        .cfg  (cfg_q),
        .p_i0 (lvl_pos[0]),
        .p_i1 (lvl_pos[1]),
        .p_a  (lvl_pos[2]),
        .p_b  (lvl_pos[3]),
        .inb  (inb),
        .addr (out_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cfg_q <= '0;
            err   <= 1'b0;
        end else begin
            if (accept) begin
                st    <= ST_RUN;
                cfg_q <= cfg_in;
                err   <= 1'b0;
            end else if (st == ST_RUN) begin
                if (!inb) err <= 1'b1;
                if (adv && (&lvl_last)) st <= ST_IDLE;
            end
        end
    end

    assign busy          = (st == ST_RUN);
    assign out_valid     = busy && inb;
    assign out_tile_last = lvl_last[0] && lvl_last[1];
    assign out_xfer_last = &lvl_last;
endmodule

// File: rtl/tag_checker.sv
module tag_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          out_valid,
    input logic          out_ready,
    input logic [AW-1:0] out_addr,
    input logic          out_tile_last,
    input logic          out_xfer_last,
    input logic          err
);
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) &&
        $stable(out_tile_last) && $stable(out_xfer_last)); // R8

    AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy); // R2

    AST_LAST_NESTING: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_xfer_last |-> out_tile_last); // R7

    AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_xfer_last |=> !busy); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        busy && err |=> err); // R9
endmodule

bind tag_addr_gen tag_checker #(.AW(tag_pkg::AW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_addr      (out_addr),
    .out_tile_last (out_tile_last),
    .out_xfer_last (out_xfer_last),
    .err           (err)
);

// File: tb/tb_tag_addr_gen.sv
module tb_tag_addr_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [7:0] buf0, buf1, tile0, tile1, off0, off1;
    logic a_dim, b_dim;
    logic [7:0] a_stride, a_wrap, b_stride, b_wrap;
    logic busy, out_valid, out_ready, out_tile_last, out_xfer_last, err;
    logic [15:0] out_addr;

    int checks = 0;
    int fails  = 0;
    int exp_addr[$];
    bit exp_tl[$];
    bit exp_xl[$];
    bit exp_err;

    always #5 clk = ~clk;

    tag_addr_gen dut (
        .clk(clk), .rst(rst), .start(start),
        .buf0(buf0), .buf1(buf1), .tile0(tile0), .tile1(tile1),
        .off0(off0), .off1(off1),
        .a_dim(a_dim), .a_stride(a_stride), .a_wrap(a_wrap),
        .b_dim(b_dim), .b_stride(b_stride), .b_wrap(b_wrap),
        .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_tile_last(out_tile_last),
        .out_xfer_last(out_xfer_last), .err(err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int b0, b1, t0, t1, o0, o1,
                           input int ad, as, aw, bd, bs, bw);
        buf0 = 8'(b0); buf1 = 8'(b1); tile0 = 8'(t0); tile1 = 8'(t1);
        off0 = 8'(o0); off1 = 8'(o1);
        a_dim = 1'(ad); a_stride = 8'(as); a_wrap = 8'(aw);
        b_dim = 1'(bd); b_stride = 8'(bs); b_wrap = 8'(bw);
    endtask

    // Reference walk built from the requirements (R3, R4, R5, R6, R7, R9)
    function automatic void build_expect();
        exp_addr.delete(); exp_tl.delete(); exp_xl.delete();
        exp_err = 1'b0;
        for (int wb = 0; wb < int'(b_wrap); wb++)
            for (int wa = 0; wa < int'(a_wrap); wa++)
                for (int i1 = 0; i1 < int'(tile1); i1++)
                    for (int i0 = 0; i0 < int'(tile0); i0++) begin
                        int c0, c1;
                        bit tl, xl;
                        c0 = int'(off0) + i0;
                        c1 = int'(off1) + i1;
                        if (a_dim) c1 += wa * int'(a_stride); else c0 += wa * int'(a_stride);
                        if (b_dim) c1 += wb * int'(b_stride); else c0 += wb * int'(b_stride);
                        tl = (i0 == int'(tile0) - 1) && (i1 == int'(tile1) - 1);
                        xl = tl && (wa == int'(a_wrap) - 1) && (wb == int'(b_wrap) - 1);
                        if (c0 >= int'(buf0) || c1 >= int'(buf1)) exp_err = 1'b1;
                        else begin
                            exp_addr.push_back(c1 * int'(buf0) + c0);
                            exp_tl.push_back(tl);
                            exp_xl.push_back(xl);
                        end
                    end
    endfunction

    task automatic run_xfer(input int rdy_pct, input bit poke, input string tag);
        int cyc = 0;
        bit stalled = 0;
        int s_addr = 0;
        bit s_tl = 0, s_xl = 0;
        int saved_b0;
        build_expect();
        saved_b0 = int'(buf0);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
        forever begin
            if (!busy) break;
            if (stalled)
                check(out_valid && int'(out_addr) == s_addr && out_tile_last == s_tl &&
                      out_xfer_last == s_xl, "R8 hold while stalled", int'(out_addr), s_addr);
            if (poke && cyc == 3) begin
                start = 1'b1;
                buf0 = buf0 + 8'd3;
                off0 = off0 + 8'd1;
            end else begin
                start = 1'b0;
            end
            out_ready = (($urandom % 100) < rdy_pct);
            #1;
            stalled = 0;
            if (out_valid) begin
                if (out_ready) begin
                    if (exp_addr.size() == 0) begin
                        check(0, {"R6 extra address ", tag}, int'(out_addr), -1);
                    end else begin
                        int ea;
                        bit et, ex;
                        ea = exp_addr.pop_front();
                        et = exp_tl.pop_front();
                        ex = exp_xl.pop_front();
                        check(int'(out_addr) == ea, {"R3/R4/R5 address ", tag}, int'(out_addr), ea);
                        check(out_tile_last == et && out_xfer_last == ex, {"R7 flags ", tag},
                              int'({out_tile_last, out_xfer_last}), int'({et, ex}));
                    end
                end else begin
                    stalled = 1;
                    s_addr = int'(out_addr);
                    s_tl = out_tile_last;
                    s_xl = out_xfer_last;
                end
            end
            @(negedge clk);
            cyc++;
            if (cyc > 5000) begin
                check(0, {"R7 transfer did not end ", tag}, cyc, 0);
                break;
            end
        end
        start = 1'b0;
        #1;
        check(exp_addr.size() == 0, {"R6 element count ", tag}, exp_addr.size(), 0);
        check(err == exp_err, {"R9 error flag ", tag}, int'(err), int'(exp_err));
        if (poke) begin
            buf0 = 8'(saved_b0);
            off0 = off0 - 8'd1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R1 watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_7a11));
        out_ready = 1'b0;
        set_cfg(12, 8, 4, 3, 0, 0, 1, 3, 2, 0, 4, 3);
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !out_valid && !err, "R1 reset state",
              int'({busy, out_valid, err}), 0);
        rst = 1'b0;

        // Column-first write pattern
        set_cfg(12, 8, 4, 3, 0, 0, 1, 3, 2, 0, 4, 3);
        run_xfer(100, 0, "R4 column-first");
        // Row-first read pattern with overlapping tiles
        set_cfg(12, 8, 7, 2, 0, 0, 0, 5, 2, 1, 2, 3);
        run_xfer(60, 0, "R6 overlap row-first");
        // Start and configuration changes while busy are ignored
        set_cfg(12, 8, 4, 3, 0, 0, 1, 3, 2, 0, 4, 3);
        run_xfer(70, 1, "R2 changes while busy");
        // Same dimension on both levels, with offset
        set_cfg(16, 6, 2, 2, 1, 1, 0, 2, 3, 0, 6, 2);
        run_xfer(50, 0, "R4 shared dimension");
        // Out-of-bounds elements skipped
        set_cfg(12, 8, 4, 3, 10, 6, 0, 4, 2, 1, 3, 2);
        run_xfer(80, 0, "R9 out of bounds");
        // Error cleared by the next accepted start
        set_cfg(8, 8, 2, 2, 0, 0, 0, 2, 2, 1, 2, 2);
        run_xfer(90, 0, "R9 cleared on start");
        // Single-element transfer
        set_cfg(5, 5, 1, 1, 4, 4, 0, 1, 1, 1, 1, 1);
        run_xfer(40, 0, "R7 single element");

        // Zero wrap count refuses the start
        set_cfg(12, 8, 4, 3, 0, 0, 0, 4, 0, 1, 3, 2);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        check(!busy && !out_valid, "R2 zero wrap refused", int'(busy), 0);

        // Constrained random transfers
        for (int n = 0; n < 25; n++) begin
            set_cfg(4 + $urandom % 13, 4 + $urandom % 9, 1 + $urandom % 5, 1 + $urandom % 5,
                    $urandom % 4, $urandom % 4,
                    $urandom % 2, 1 + $urandom % 6, 1 + $urandom % 3,
                    $urandom % 2, 1 + $urandom % 6, 1 + $urandom % 3);
            run_xfer(30 + $urandom % 71, 0, "R5 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule